// File: doc/BRIEF.md
# Line-Doubled Monochrome Raster Scanout

This block drives a monochrome raster display from a framebuffer of one bit per pixel. The framebuffer is packed into 16-bit words and holds half as many rows as the display has lines. A horizontal and a vertical counter step once per pixel-clock enable and produce active-low horizontal and vertical sync. Inside a vertical window that starts at a programmable line, each stored row is serialized onto two consecutive scanlines.

Each line's pixels start at a fixed horizontal count. They are read through a synchronous memory port that has one clock of read latency, and each word is shifted out least significant bit first. The block is meant to sit beside a framebuffer RAM. The RAM, the drawing of content into it and any analogue conversion are handled by other logic.

All three outputs are registered. The values seen after the n-th accepted pixel-clock enable (counting from 0 after `en` rises) belong to pixel slot n. Slot n has horizontal count h = n mod H_TOTAL and line v = (n div H_TOTAL) mod V_TOTAL.

Top module: `fb_scanout`

## Requirements
- R1: While `en` is low, the edge after it leaves `hsync_n` and `vsync_n` high and `video` at 0, and the counters are held at zero. Reset gives the same state. After `en` rises, the first accepted pixel enable emits slot 0.
- R2: `hsync_n` is low exactly for the slots with HS_START <= h < HS_END (656..719 of 800 by default) and high for all others.
- R3: The line count advances once per horizontal wrap. `vsync_n` is low exactly on lines VS_START <= v < VS_END (481..483 of 497 by default).
- R4: When `en` is high and `pix_en` is low, `hsync_n`, `vsync_n`, `video` and `mem_addr` do not change.
- R5: For h in [SCAN_START, SCAN_START + 16*WORDS), `video` carries bit (h - SCAN_START) mod 16 of fetched word (h - SCAN_START) div 16. Bit 0 of each word is sent first. SCAN_START is 90 by default.
- R6: Each line fetches WORDS = (FB_WIDTH/8 + 2)/2 consecutive words, starting at the row address. That is 21 words for a width of 320. `mem_rdata` is taken one clock after `mem_addr`. While disabled, `mem_addr` follows `fb_base`.
- R7: The vertical window covers lines v_start <= v < v_start + 2*FB_HEIGHT. On every line outside it, `video` is 0.
- R8: Inside the window, line v shows stored row r = (v - v_start) div 2. That row is read from address fb_base + r*fb_stride, modulo 2^ADDR_W. Each row therefore appears on two consecutive lines.
- R9: `video` is 0 for every h outside the scan interval, even when the fetched words are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; low holds the counters at zero and idles the outputs |
| pix_en | input | 1 | Pixel-clock enable; one pixel slot per accepted cycle |
| v_start | input | VC_W | First line of the vertical window |
| fb_base | input | ADDR_W | Word address of stored row 0 |
| fb_stride | input | ADDR_W | Words between consecutive stored rows |
| mem_addr | output | ADDR_W | Framebuffer read address |
| mem_rdata | input | WORD_W | Read data, valid one clock after the address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video | output | 1 | Serial pixel output |

## Verification
The bench builds the block with a reduced raster: 64 slots per line, 16 lines per frame, a 32-pixel by 4-row framebuffer (3 words per line), a scan start of 6 and 8-bit addresses. With this raster a whole frame is 1024 slots, so every slot of several complete frames can be compared against values worked out arithmetically. Runs vary the window start, including a window that runs up to the last line of the frame, and vary base and stride, including address wrap. Pixel enables arrive both back to back and with idle gaps. Disabling part way through a frame shows that the slot numbering restarts. A region of all-ones words shows that blanking outside the scan interval and outside the window holds even when the data is non-zero.

// File: rtl/fbs_pkg.sv
`timescale 1ns/1ps
package fbs_pkg;

  // Words fetched per line: one word more than the visible width needs
  // when the width is a whole number of words.
  function automatic int words_per_line(input int fb_width, input int word_w);
    int bytes_per_word;
    bytes_per_word = word_w / 8;
    return ((fb_width / 8) + bytes_per_word) / bytes_per_word;
  endfunction

endpackage

// File: rtl/fbs_timing.sv
`timescale 1ns/1ps
module fbs_timing #(
  parameter int H_TOTAL  = 800,
  parameter int HS_START = 656,
  parameter int HS_END   = 720,
  parameter int V_TOTAL  = 497,
  parameter int VS_START = 481,
  parameter int VS_END   = 484,
  parameter int HC_W     = $clog2(H_TOTAL),
  parameter int VC_W     = $clog2(V_TOTAL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            pix_en,
  output logic [HC_W-1:0] h_cnt,
  output logic [VC_W-1:0] v_cnt,
  output logic            adv,
  output logic            line_end,
  output logic            hsync_n,
  output logic            vsync_n
);

  localparam logic [HC_W-1:0] H_LAST = HC_W'(H_TOTAL - 1);
  localparam logic [VC_W-1:0] V_LAST = VC_W'(V_TOTAL - 1);
  localparam logic [HC_W-1:0] HS_A   = HC_W'(HS_START);
  localparam logic [HC_W-1:0] HS_B   = HC_W'(HS_END);
  localparam logic [VC_W-1:0] VS_A   = VC_W'(VS_START);
  localparam logic [VC_W-1:0] VS_B   = VC_W'(VS_END);

  logic [HC_W-1:0] h_nxt;
  logic [VC_W-1:0] v_nxt;
  logic            hs_nxt;
  logic            vs_nxt;

  always_comb begin
    adv      = en & pix_en;
    line_end = adv && (h_cnt == H_LAST);
  end

  always_comb begin
    h_nxt  = h_cnt;
    v_nxt  = v_cnt;
    hs_nxt = hsync_n;
    vs_nxt = vsync_n;
    if (!en) begin
      h_nxt  = '0;
      v_nxt  = '0;
      hs_nxt = 1'b1;
      vs_nxt = 1'b1;
    end else if (pix_en) begin
      // outputs describe the slot the counters point at before the step
      hs_nxt = !((h_cnt >= HS_A) && (h_cnt < HS_B));
      vs_nxt = !((v_cnt >= VS_A) && (v_cnt < VS_B));
      if (h_cnt == H_LAST) begin
        h_nxt = '0;
        v_nxt = (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
      end else begin
        h_nxt = h_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt   <= '0;
      v_cnt   <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      h_cnt   <= h_nxt;
      v_cnt   <= v_nxt;
      hsync_n <= hs_nxt;
      vsync_n <= vs_nxt;
    end
  end

endmodule

// File: rtl/fbs_rowaddr.sv
`timescale 1ns/1ps
module fbs_rowaddr #(
  parameter int ADDR_W     = 16,
  parameter int HC_W       = 10,
  parameter int VC_W       = 9,
  parameter int WIN_LINES  = 480,
  parameter int SCAN_START = 90,
  parameter int WORDS      = 21,
  parameter int WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic              line_end,
  input  logic [HC_W-1:0]   h_cnt,
  input  logic [VC_W-1:0]   v_cnt,
  input  logic [VC_W-1:0]   v_start,
  input  logic [ADDR_W-1:0] fb_base,
  input  logic [ADDR_W-1:0] fb_stride,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              in_win,
  output logic              load_word
);

  localparam int WW         = VC_W + 2;
  localparam int BIT_W      = $clog2(WORD_W);
  localparam int LOAD_FIRST = SCAN_START - 1;
  localparam int LOAD_END   = LOAD_FIRST + WORDS * WORD_W;
  localparam logic [HC_W-1:0]  LF_H  = HC_W'(LOAD_FIRST);
  localparam logic [HC_W-1:0]  LE_H  = HC_W'(LOAD_END);
  localparam logic [BIT_W-1:0] LF_LO = BIT_W'(LOAD_FIRST);

  logic [WW-1:0]     v_ext;
  logic [WW-1:0]     s_ext;
  logic [WW-1:0]     e_ext;
  logic              odd_line;
  logic [BIT_W-1:0]  rel_lo;
  logic [ADDR_W-1:0] row_ptr;
  logic [ADDR_W-1:0] row_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  // vertical window decode, widened so start + length cannot wrap
  always_comb begin
    v_ext    = WW'(v_cnt);
    s_ext    = WW'(v_start);
    e_ext    = s_ext + WW'(WIN_LINES);
    in_win   = (v_ext >= s_ext) && (v_ext < e_ext);
    odd_line = v_cnt[0] ^ v_start[0];
  end

  // one word capture every WORD_W slots, one slot ahead of its first pixel
  always_comb begin
    rel_lo    = h_cnt[BIT_W-1:0] - LF_LO;
    load_word = adv && (h_cnt >= LF_H) && (h_cnt < LE_H) && (rel_lo == '0);
  end

  always_comb begin
    row_nxt  = row_ptr;
    addr_nxt = mem_addr;
    if (!en) begin
      row_nxt  = fb_base;
      addr_nxt = fb_base;
    end else if (line_end) begin
      if (!in_win)
        row_nxt = fb_base;
      else if (odd_line)
        row_nxt = row_ptr + fb_stride;
      addr_nxt = row_nxt;
    end else if (load_word) begin
      addr_nxt = mem_addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_ptr  <= '0;
      mem_addr <= '0;
    end else begin
      row_ptr  <= row_nxt;
      mem_addr <= addr_nxt;
    end
  end

endmodule

// File: rtl/fbs_shifter.sv
`timescale 1ns/1ps
module fbs_shifter #(
  parameter int WORD_W     = 16,
  parameter int HC_W       = 10,
  parameter int SCAN_START = 90,
  parameter int SCAN_BITS  = 336
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic              load_word,
  input  logic [HC_W-1:0]   h_cnt,
  input  logic              in_win,
  input  logic [WORD_W-1:0] rd_data,
  output logic              video
);

  localparam logic [HC_W-1:0] SC_A = HC_W'(SCAN_START);
  localparam logic [HC_W-1:0] SC_B = HC_W'(SCAN_START + SCAN_BITS);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shreg_nxt;
  logic              video_nxt;
  logic              in_scan;

  always_comb begin
    in_scan   = (h_cnt >= SC_A) && (h_cnt < SC_B);
    shreg_nxt = shreg;
    video_nxt = video;
    if (!en) begin
      shreg_nxt = '0;
      video_nxt = 1'b0;
    end else if (adv) begin
      video_nxt = in_scan && in_win && shreg[0];
      shreg_nxt = load_word ? rd_data : {1'b0, shreg[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      video <= 1'b0;
    end else begin
      shreg <= shreg_nxt;
      video <= video_nxt;
    end
  end

endmodule

// File: rtl/fb_scanout.sv
`timescale 1ns/1ps
module fb_scanout #(
  parameter int FB_WIDTH   = 320,
  parameter int FB_HEIGHT  = 240,
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 16,
  parameter int H_ACTIVE   = 640,
  parameter int HS_START   = 656,
  parameter int HS_END     = 720,
  parameter int H_TOTAL    = 800,
  parameter int V_ACTIVE   = 480,
  parameter int VS_START   = 481,
  parameter int VS_END     = 484,
  parameter int V_TOTAL    = 497,
  parameter int SCAN_START = 90,
  localparam int HC_W      = $clog2(H_TOTAL),
  localparam int VC_W      = $clog2(V_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pix_en,
  input  logic [VC_W-1:0]   v_start,
  input  logic [ADDR_W-1:0] fb_base,
  input  logic [ADDR_W-1:0] fb_stride,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              video
);

  localparam int WORDS     = fbs_pkg::words_per_line(FB_WIDTH, WORD_W);
  localparam int SCAN_BITS = WORDS * WORD_W;
  localparam int WIN_LINES = 2 * FB_HEIGHT;

  generate
    if (SCAN_START < 2)
      begin : g_bad_start  $error("scan start must leave two slots for the first fetch"); end
    if (SCAN_START + SCAN_BITS > H_ACTIVE)
      begin : g_bad_width  $error("scan interval exceeds the active width"); end
    if (H_ACTIVE > HS_START || HS_START >= HS_END || HS_END > H_TOTAL)
      begin : g_bad_htime  $error("horizontal timing out of order"); end
    if (V_ACTIVE > VS_START || VS_START >= VS_END || VS_END > V_TOTAL)
      begin : g_bad_vtime  $error("vertical timing out of order"); end
    if (WIN_LINES > V_TOTAL)
      begin : g_bad_window $error("window longer than a frame"); end
    if ((WORD_W % 8) != 0 || (1 << $clog2(WORD_W)) != WORD_W)
      begin : g_bad_word   $error("word width must be a power of two of whole bytes"); end
  endgenerate

  logic [HC_W-1:0] h_cnt;
  logic [VC_W-1:0] v_cnt;
  logic            adv;
  logic            line_end;
  logic            in_win;
  logic            load_word;

  fbs_timing #(
    .H_TOTAL (H_TOTAL),  .HS_START(HS_START), .HS_END(HS_END),
    .V_TOTAL (V_TOTAL),  .VS_START(VS_START), .VS_END(VS_END),
    .HC_W    (HC_W),     .VC_W    (VC_W)
  ) u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pix_en   (pix_en),
    .h_cnt    (h_cnt),
    .v_cnt    (v_cnt),
    .adv      (adv),
    .line_end (line_end),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n)
  );

  fbs_rowaddr #(
    .ADDR_W    (ADDR_W),    .HC_W  (HC_W),  .VC_W  (VC_W),
    .WIN_LINES (WIN_LINES), .SCAN_START(SCAN_START),
    .WORDS     (WORDS),     .WORD_W(WORD_W)
  ) u_rowaddr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .adv       (adv),
    .line_end  (line_end),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .v_start   (v_start),
    .fb_base   (fb_base),
    .fb_stride (fb_stride),
    .mem_addr  (mem_addr),
    .in_win    (in_win),
    .load_word (load_word)
  );

  fbs_shifter #(
    .WORD_W    (WORD_W),    .HC_W(HC_W),
    .SCAN_START(SCAN_START), .SCAN_BITS(SCAN_BITS)
  ) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .adv       (adv),
    .load_word (load_word),
    .h_cnt     (h_cnt),
    .in_win    (in_win),
    .rd_data   (mem_rdata),
    .video     (video)
  );

endmodule

// File: rtl/fbs_checker.sv
`timescale 1ns/1ps
module fbs_checker #(
  parameter int HS_WIDTH = 64,
  parameter int ADDR_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              pix_en,
  input logic [ADDR_W-1:0] fb_base,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic              video
);

  localparam int CNT_W = $clog2(HS_WIDTH + 2);

  logic [CNT_W-1:0] hs_len;

  // pixel slots counted while the horizontal pulse is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hs_len <= '0;
    else if (!en || hsync_n)
      hs_len <= '0;
    else if (pix_en)
      hs_len <= hs_len + 1'b1;
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hsync_n && vsync_n && !video));                              // R1

  AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hsync_n) && hs_len != '0) |-> (hs_len == CNT_W'(HS_WIDTH)));   // R2

  AST_VSYNC_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> (hsync_n && !video));                              // R3

  AST_HOLD_NO_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pix_en) |=> ($stable(hsync_n) && $stable(vsync_n)
                         && $stable(video) && $stable(mem_addr)));        // R4

  AST_ADDR_BASE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (mem_addr == $past(fb_base)));                                // R6

  AST_NO_VIDEO_IN_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> !video);                                                 // R9

endmodule

bind fb_scanout fbs_checker #(
  .HS_WIDTH(HS_END - HS_START),
  .ADDR_W  (ADDR_W)
) u_fbs_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .pix_en  (pix_en),
  .fb_base (fb_base),
  .mem_addr(mem_addr),
  .hsync_n (hsync_n),
  .vsync_n (vsync_n),
  .video   (video)
);

// File: tb/fb_scanout_bench.sv
`timescale 1ns/1ps
module fb_scanout_bench;

  localparam int FBW = 32;
  localparam int FBH = 4;
  localparam int HA  = 56;
  localparam int HSA = 58;
  localparam int HSB = 62;
  localparam int HT  = 64;
  localparam int VA  = 12;
  localparam int VSA = 13;
  localparam int VSB = 15;
  localparam int VT  = 16;
  localparam int SS  = 6;
  localparam int AW  = 8;
  localparam int NW  = (FBW / 8 + 2) / 2;
  localparam int SB  = NW * 16;
  localparam int WIN = 2 * FBH;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic          pix_en;
  logic [3:0]    v_start;
  logic [AW-1:0] fb_base;
  logic [AW-1:0] fb_stride;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_rdata;
  logic          hsync_n;
  logic          vsync_n;
  logic          video;

  logic [15:0] mem [256];
  int total = 0;
  int bad   = 0;
  int slot_n;
  int cfg_voff, cfg_base, cfg_stride;

  always #4 clk = ~clk;

  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  fb_scanout #(
    .FB_WIDTH(FBW), .FB_HEIGHT(FBH), .WORD_W(16), .ADDR_W(AW),
    .H_ACTIVE(HA), .HS_START(HSA), .HS_END(HSB), .H_TOTAL(HT),
    .V_ACTIVE(VA), .VS_START(VSA), .VS_END(VSB), .V_TOTAL(VT),
    .SCAN_START(SS)
  ) u_fb_scanout (
    .clk(clk), .rst_n(rst_n), .en(en), .pix_en(pix_en),
    .v_start(v_start), .fb_base(fb_base), .fb_stride(fb_stride),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .video(video)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s slot=%0d actual=%0d expected=%0d", req, slot_n, act, exp);
    end
  endtask

  function automatic bit in_window(input int ln);
    return (ln >= cfg_voff) && (ln < cfg_voff + WIN);
  endfunction

  function automatic bit exp_video(input int n);
    int h, ln, row, w, b, a;
    h  = n % HT;
    ln = (n / HT) % VT;
    if (!in_window(ln)) return 1'b0;
    if (h < SS || h >= SS + SB) return 1'b0;
    row = (ln - cfg_voff) / 2;
    w   = (h - SS) / 16;
    b   = (h - SS) % 16;
    a   = (cfg_base + row * cfg_stride + w) % 256;
    return mem[a][b];
  endfunction

  task automatic check_slot(input int n);
    int h, ln;
    bit ehs, evs, ev;
    string tag;
    h   = n % HT;
    ln  = (n / HT) % VT;
    ehs = !(h >= HSA && h < HSB);
    evs = !(ln >= VSA && ln < VSB);
    ev  = exp_video(n);
    chk(hsync_n == ehs, "R2 hsync", int'(hsync_n), int'(ehs));
    chk(vsync_n == evs, "R3 vsync", int'(vsync_n), int'(evs));
    if (!in_window(ln))             tag = "R7 video outside window";
    else if (h < SS || h >= SS + SB) tag = "R9 video outside scan";
    else                            tag = "R5 R6 R8 video pixel";
    chk(video == ev, tag, int'(video), int'(ev));
  endtask

  // one accepted pixel enable per slot, then gap idle cycles
  task automatic run_slots(input int count, input int gap);
    for (int k = 0; k < count; k++) begin
      pix_en = 1'b1;
      @(negedge clk);
      check_slot(slot_n);
      slot_n++;
      for (int g = 0; g < gap; g++) begin
        logic hs0, vs0, v0;
        logic [AW-1:0] a0;
        hs0 = hsync_n; vs0 = vsync_n; v0 = video; a0 = mem_addr;
        pix_en = 1'b0;
        @(negedge clk);
        chk({hsync_n, vsync_n, video} == {hs0, vs0, v0}, "R4 outputs held",
            int'({hsync_n, vsync_n, video}), int'({hs0, vs0, v0}));
        chk(mem_addr == a0, "R4 address held", int'(mem_addr), int'(a0));
      end
    end
    pix_en = 1'b0;
  endtask

  task automatic start_cfg(input int voff, input int base, input int stride);
    en         = 1'b0;
    pix_en     = 1'b1;
    cfg_voff   = voff;
    cfg_base   = base;
    cfg_stride = stride;
    v_start    = 4'(voff);
    fb_base    = AW'(base);
    fb_stride  = AW'(stride);
    @(negedge clk);
    @(negedge clk);
    chk(hsync_n && vsync_n && !video, "R1 idle while disabled",
        int'({hsync_n, vsync_n, video}), 6);
    chk(mem_addr == AW'(base), "R6 address follows base while disabled",
        int'(mem_addr), base);
    pix_en = 1'b0;
    en     = 1'b1;
    slot_n = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503) ^ 16'hA5C3);
    rst_n = 1'b0; en = 1'b0; pix_en = 1'b0;
    v_start = '0; fb_base = '0; fb_stride = '0;
    slot_n = 0; cfg_voff = 0; cfg_base = 0; cfg_stride = 0;
    repeat (3) @(negedge clk);
    chk(hsync_n && vsync_n && !video, "R1 reset state",
        int'({hsync_n, vsync_n, video}), 6);
    chk(mem_addr == '0, "R1 reset address", int'(mem_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // back-to-back pixels, two frames
    start_cfg(3, 5, 3);
    run_slots(2 * HT * VT, 0);

    // interrupted frame: numbering must restart at slot 0 (R1)
    start_cfg(0, 250, 7);
    run_slots(300, 0);
    start_cfg(0, 250, 7);
    run_slots(HT * VT + 70, 2);

    // window reaching the last line, unit stride
    start_cfg(8, 0, 1);
    run_slots(HT * VT, 1);

    // all-ones data: blanking must hold outside scan and window (R9, R7)
    for (int i = 100; i < 128; i++) mem[i] = 16'hFFFF;
    start_cfg(12, 100, 4);
    run_slots(HT * VT, 0);

    // zero stride repeats one row on every window line (R8)
    start_cfg(2, 40, 0);
    run_slots(HT * VT, 0);

    en = 1'b0;
    @(negedge clk);
    chk(hsync_n && vsync_n && !video, "R1 idle after final disable",
        int'({hsync_n, vsync_n, video}), 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule